// File: doc/BRIEF.md
# Signed Dadda Tree Multiplier

This block multiplies two signed N-bit operands and returns the full 2N-bit two's complement product, with no clock in its data path. Each operand bit pair produces one partial-product bit. The bits in which exactly one factor is a sign bit are inverted, and a constant one is added in column N and in column 2N-1. After this step every bit of the matrix carries a positive weight, and the sum of the matrix is already the signed product.

The matrix is compressed column by column with half and full adders. Each level shrinks every column to a target height. The targets are the values 2, 3, 4, 6, 9, 13 and so on, where each value is the previous one times one and a half, rounded down. Each level uses the largest value that is still below the tallest column. Columns are visited from least to most significant. A column counts the carries it has received from its lower neighbour before it decides what to do. It uses a half adder when it is exactly one bit too tall, and otherwise full adders. Each sum stays in the column and each carry moves one column up. When no column holds more than two bits, a logarithmic-depth prefix adder adds the two rows. The operand width N is a parameter.

Top module: `signed_dadda_mul`

## Requirements
- R1: For every pair of signed operands, `product` equals their two's complement product, 2N bits wide, with bit 0 least significant.
- R2: The most negative operand times itself gives +2^(2N-2): bit 2N-2 is set and every other bit, including sign bit 2N-1, is zero.
- R3: If either operand is zero, `product` is zero.
- R4: If one operand is +1, `product` is the other operand sign-extended to 2N bits.
- R5: If one operand is -1 (all ones), `product` is the two's complement negation of the other operand in 2N bits. The most negative operand yields +2^(N-1).
- R6: The block is purely combinational. `product` reflects new operands in the same clock cycle they are applied, and any carry out of column 2N-1 is dropped.
- R7: The result is correct for N = 4, N = 8 and N = 16 with the same source.
- R8: For nonzero operands, sign bit 2N-1 of `product` is set exactly when one operand is negative and the other is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | N | Signed multiplicand, two's complement |
| mplier | input | N | Signed multiplier, two's complement |
| product | output | 2N | Signed product, two's complement |

## Verification
At N = 4 every operand pair is applied, which covers each inverted sign-bit term and both constant ones in every combination. At N = 8 a fixed table mixes zero, plus and minus one, small odd values, alternating bit patterns and the extremes of the range. These cases separate a wrong inversion, which breaks mixed-sign results, from a misplaced constant, which breaks results where both operands are negative, and from a lost column carry, which breaks the largest magnitudes. At N = 16, random pairs and the case of the most negative value squared exercise the deeper reduction levels and the top-column carry that must be dropped.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

    // What one step of column reduction does
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_HALF = 2'd1,
        ACT_FULL = 2'd2
    } red_act_e;

    // Largest member of 2,3,4,6,9,... that is strictly below the tallest column
    function automatic int dadda_target(input int tallest);
        int h;
        h = 2;
        while (((h * 3) / 2) < tallest) begin
            h = (h * 3) / 2;
        end
        return h;
    endfunction

    // Number of reduction levels needed when the tallest column starts at n
    function automatic int dadda_level_count(input int n);
        int h;
        int cnt;
        h   = 2;
        cnt = 0;
        while (h < n) begin
            cnt = cnt + 1;
            h   = (h * 3) / 2;
        end
        return cnt;
    endfunction

    function automatic logic csa_sum(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic csa_carry(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/bw_ppgen.sv
module bw_ppgen #(
    parameter int N = 8
) (
    input  logic [N-1:0]   op_x,
    input  logic [N-1:0]   op_y,
    output logic [N*N-1:0] pp_bits
);
    // pp_bits[i*N+j] has weight 2^(i+j); sign-cross terms are inverted
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam bit FLIP = (i == N - 1) ^ (j == N - 1);
            if (FLIP) begin : g_inv
                assign pp_bits[i*N+j] = ~(op_x[i] & op_y[j]);
            end else begin : g_pos
                assign pp_bits[i*N+j] = op_x[i] & op_y[j];
            end
        end
    end

endmodule

// File: rtl/dadda_compress.sv
module dadda_compress
    import dadda_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*N-1:0] pp_bits,
    output logic [2*N-1:0] row_a,
    output logic [2*N-1:0] row_b
);
    localparam int W      = 2 * N;
    localparam int QD     = 4 * N + 4;
    localparam int LEVELS = dadda_level_count(N);

    always_comb begin
        logic [QD-1:0] q  [W];
        logic [QD-1:0] nq [W];
        int            hd [W];
        int            tl [W];
        int            tallest;
        int            target;
        int            len;
        logic          x0, x1, x2;
        red_act_e      act;

        x0  = 1'b0;
        x1  = 1'b0;
        x2  = 1'b0;
        act = ACT_KEEP;
        for (int c = 0; c < W; c++) begin
            q[c]  = '0;
            nq[c] = '0;
            hd[c] = 0;
            tl[c] = 0;
        end

        // Load the bit matrix: column i+j receives pp(i,j)
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                q[i+j][tl[i+j]] = pp_bits[i*N+j];
                tl[i+j]         = tl[i+j] + 1;
            end
        end
        // Correction ones of the all-positive signed form
        q[N][tl[N]]     = 1'b1;
        tl[N]           = tl[N] + 1;
        q[W-1][tl[W-1]] = 1'b1;
        tl[W-1]         = tl[W-1] + 1;

        for (int lv = 0; lv < LEVELS; lv++) begin
            tallest = 0;
            for (int c = 0; c < W; c++) begin
                if (tl[c] - hd[c] > tallest) tallest = tl[c] - hd[c];
            end
            target = dadda_target(tallest);

            // Low to high, so incoming carries are counted first
            for (int c = 0; c < W; c++) begin
                len = tl[c] - hd[c];
                while (len > target) begin
                    act = (len - target == 1) ? ACT_HALF : ACT_FULL;
                    unique case (act)
                        ACT_HALF: begin
                            x0    = q[c][hd[c]];
                            x1    = q[c][hd[c]+1];
                            x2    = 1'b0;
                            hd[c] = hd[c] + 2;
                            len   = len - 1;
                        end
                        ACT_FULL: begin
                            x0    = q[c][hd[c]];
                            x1    = q[c][hd[c]+1];
                            x2    = q[c][hd[c]+2];
                            hd[c] = hd[c] + 3;
                            len   = len - 2;
                        end
                        ACT_KEEP: begin
                            x0  = 1'b0;
                            x1  = 1'b0;
                            x2  = 1'b0;
                            len = target;
                        end
                    endcase
                    q[c][tl[c]] = csa_sum(x0, x1, x2);
                    tl[c]       = tl[c] + 1;
                    if (c + 1 < W) begin
                        q[c+1][tl[c+1]] = csa_carry(x0, x1, x2);
                        tl[c+1]         = tl[c+1] + 1;
                    end
                end
            end

            // Drop consumed entries so every column restarts at index 0
            for (int c = 0; c < W; c++) begin
                nq[c] = '0;
                for (int k = 0; k < QD; k++) begin
                    if (k < tl[c] - hd[c]) nq[c][k] = q[c][hd[c]+k];
                end
                q[c]  = nq[c];
                tl[c] = tl[c] - hd[c];
                hd[c] = 0;
            end
        end

        for (int c = 0; c < W; c++) begin
            row_a[c] = (tl[c] > 0) ? q[c][0] : 1'b0;
            row_b[c] = (tl[c] > 1) ? q[c][1] : 1'b0;
        end
    end

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    output logic [W-1:0] add_sum
);
    localparam int STG = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] gen  [STG+1];
    logic [W-1:0] prop [STG+1];
    logic         unused_top;

    assign gen[0]  = add_x & add_y;
    assign prop[0] = add_x ^ add_y;

    for (genvar s = 1; s <= STG; s++) begin : g_stage
        localparam int D = 1 << (s - 1);
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_merge
                assign gen[s][i]  = gen[s-1][i] | (prop[s-1][i] & gen[s-1][i-D]);
                assign prop[s][i] = prop[s-1][i] & prop[s-1][i-D];
            end else begin : g_pass
                assign gen[s][i]  = gen[s-1][i];
                assign prop[s][i] = prop[s-1][i];
            end
        end
    end

    assign add_sum[0] = prop[0][0];
    for (genvar i = 1; i < W; i++) begin : g_sum
        assign add_sum[i] = prop[0][i] ^ gen[STG][i-1];
    end

    // Carry out of the top bit is discarded
    assign unused_top = ^{prop[STG], gen[STG][W-1]};

endmodule

// File: rtl/signed_dadda_mul.sv
module signed_dadda_mul #(
    parameter int N = 8
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);
    localparam int W = 2 * N;

    logic [N*N-1:0] pp_bits;
    logic [W-1:0]   row_a;
    logic [W-1:0]   row_b;

    bw_ppgen #(.N(N)) u_ppgen (
        .op_x    (mcand),
        .op_y    (mplier),
        .pp_bits (pp_bits)
    );

    dadda_compress #(.N(N)) u_tree (
        .pp_bits (pp_bits),
        .row_a   (row_a),
        .row_b   (row_b)
    );

    prefix_adder #(.W(W)) u_final (
        .add_x   (row_a),
        .add_y   (row_b),
        .add_sum (product)
    );

endmodule

// File: rtl/signed_dadda_mul_chk.sv
module signed_dadda_mul_chk #(
    parameter int N = 8
) (
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic [2*N-1:0] product
);
    localparam int W = 2 * N;

    logic signed [W-1:0] ext_a;
    logic signed [W-1:0] ext_b;
    logic signed [W-1:0] ref_p;
    logic [N-1:0]        most_neg;

    always_comb begin
        ext_a    = W'($signed(mcand));
        ext_b    = W'($signed(mplier));
        ref_p    = ext_a * ext_b;
        most_neg = {1'b1, {(N-1){1'b0}}};
        if (!$isunknown({mcand, mplier, product})) begin
            // R1
            product_exact_chk: assert (product == ref_p)
                else $error("product mismatch");
            // R3
            zero_operand_chk: assert (!((mcand == '0) || (mplier == '0)) || (product == '0))
                else $error("zero operand gave nonzero product");
            // R4
            unit_factor_chk: assert ((mplier != N'(1)) || (product == ext_a))
                else $error("times one differs from operand");
            // R5
            neg_unit_chk: assert ((mplier != '1) || (product == -ext_a))
                else $error("times minus one differs from negation");
            // R2
            min_square_chk: assert (!((mcand == most_neg) && (mplier == most_neg))
                                    || (product == (W'(1) << (W - 2))))
                else $error("most negative squared wrong");
            // R8
            sign_rule_chk: assert ((mcand == '0) || (mplier == '0)
                                   || (product[W-1] == (mcand[N-1] ^ mplier[N-1])))
                else $error("product sign wrong");
        end
    end

endmodule

bind signed_dadda_mul signed_dadda_mul_chk #(.N(N)) u_chk (
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
);

// File: tb/tb_signed_dadda_mul.sv
`timescale 1ns/1ps
module tb_signed_dadda_mul;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  a8  = '0, b8  = '0;
    logic [15:0] p8;
    logic [3:0]  a4  = '0, b4  = '0;
    logic [7:0]  p4;
    logic [15:0] a16 = '0, b16 = '0;
    logic [31:0] p16;

    signed_dadda_mul #(.N(8))  dut     (.mcand(a8),  .mplier(b8),  .product(p8));
    signed_dadda_mul #(.N(4))  dut_n4  (.mcand(a4),  .mplier(b4),  .product(p4));
    signed_dadda_mul #(.N(16)) dut_n16 (.mcand(a16), .mplier(b16), .product(p16));

    // {mcand, mplier, expected product} for N = 8
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'h00, 16'h0000},   // R3 zero times zero
        {8'h01, 8'h01, 16'h0001},   // R4
        {8'h07, 8'h06, 16'h002A},   // R1 small positive
        {8'hFF, 8'hFF, 16'h0001},   // R5 minus one squared
        {8'h80, 8'h80, 16'h4000},   // R2 most negative squared
        {8'h80, 8'h7F, 16'hC080},   // R8 extremes, mixed sign
        {8'h7F, 8'h7F, 16'h3F01},   // R1 largest positive
        {8'hFF, 8'h01, 16'hFFFF},   // R4 sign extension
        {8'hFD, 8'h05, 16'hFFF1},   // R8 negative times positive
        {8'h64, 8'hF9, 16'hFD44},   // R8 positive times negative
        {8'h55, 8'hAA, 16'hE372},   // R1 alternating bits
        {8'h7F, 8'h80, 16'hC080}    // R1 operand order swapped
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Operands idle at zero during reset: R3
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R3 idle", {48'd0, p8}, 64'd0);
        rst = 1'b0;

        // Table for N = 8: R1 R2 R4 R5 R8; sampled in the cycle of application (R6)
        for (int v = 0; v < NV; v++) begin
            settle();
            a8 = VEC[v][31:24];
            b8 = VEC[v][23:16];
            @(negedge clk);
            chk("R1 table", {48'd0, p8}, {48'd0, VEC[v][15:0]});
        end

        // Exhaustive N = 4: R7 R1
        for (int x = -8; x < 8; x++) begin
            for (int y = -8; y < 8; y++) begin
                settle();
                a4 = 4'(x);
                b4 = 4'(y);
                @(negedge clk);
                chk("R7 n4", {56'd0, p4}, {56'd0, 8'(x * y)});
            end
        end

        // Random N = 16: R7 R1
        for (int r = 0; r < 400; r++) begin
            logic signed [31:0] sx, sy;
            settle();
            a16 = 16'($urandom);
            b16 = 16'($urandom);
            sx  = 32'($signed(a16));
            sy  = 32'($signed(b16));
            @(negedge clk);
            chk("R7 n16", {32'd0, p16}, {32'd0, 32'(sx * sy)});
        end

        // Corner cases across widths
        settle();
        a16 = 16'h8000; b16 = 16'h8000; a4 = 4'h8; b4 = 4'h8;
        @(negedge clk);
        chk("R2 n16", {32'd0, p16}, 64'h0000_0000_4000_0000);
        chk("R2 n4",  {56'd0, p4},  64'h40);

        settle();
        a16 = 16'hFFFF; b16 = 16'h8000; a8 = 8'hFF; b8 = 8'h80;
        @(negedge clk);
        chk("R5 n16", {32'd0, p16}, 64'h0000_0000_0000_8000);
        chk("R5 n8",  {48'd0, p8},  64'h0080);

        settle();
        a16 = 16'h0000; b16 = 16'h8000; a8 = 8'h01; b8 = 8'h9C;
        @(negedge clk);
        chk("R3 n16", {32'd0, p16}, 64'd0);
        chk("R4 n8",  {48'd0, p8},  64'hFF9C);

        // R6: top-column carry dropped, new operands visible without waiting
        settle();
        a16 = 16'hFFFF; b16 = 16'hFFFF;
        #1;
        chk("R6 n16", {32'd0, p16}, 64'h1);
        a16 = 16'h7FFF; b16 = 16'h8001;
        #1;
        chk("R6 n16 change", {32'd0, p16}, 64'h0000_0000_C000_FFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule